// File: doc/BRIEF.md
# AES Byte-Operation Execution Unit

This unit sits in the execute stage of a 32-bit RISC datapath and gives it single-cycle AES byte operations. Each issued operation presents two 32-bit operands and a set of function enables. At most one function is carried out:

- a multiply in GF(2^8),
- a four-lane byte substitution, where each S-box output is computed as a field inverse followed by the affine map,
- a byte rotation of one state row.

When no enable is raised, the unit falls back to a bitwise XOR of the operands. This XOR is both field addition and the round-key addition step.

The result is registered, so it appears one clock after the operation is issued, together with a valid flag. When no operation is issued, the previous result is held. The substitution lanes are pure logic rather than a stored table. The unit therefore needs no memory and no initialisation.

Top module: `aesx_unit`

## Requirements
- R1: While `rst` is high, `res` is driven to 0 and `res_valid` to 0 on every clock edge.
- R2: An operation issued with `in_valid` high in one cycle appears on `res`, with `res_valid` high, after the next rising edge. When `in_valid` is low, `res_valid` falls and `res` keeps its last value.
- R3: Enables are resolved by priority: `en_gfm` first, then `en_sub`, then `en_rot`, then the XOR fallback. Only the winning function determines `res`.
- R4: With `en_gfm`, `res[7:0]` is the product of `op_a[7:0]` and `op_b[7:0]` in GF(2^8), reduced by x^8+x^4+x^3+x+1. `res[31:8]` is 0. Examples: 0x57·0x83 = 0xC1, 0x57·0x13 = 0xFE, 0x02·0x87 = 0x15, 0x00·x = 0x00.
- R5: With `en_sub`, each byte of `op_a` is replaced in parallel by its AES S-box value. The S-box value is the inverse in GF(2^8), with 0x00 kept as 0x00, followed by the affine map with constant 0x63. Examples: 0x00→0x63, 0x01→0x7C, 0x53→0xED, 0xFF→0x16, 0x11→0x82, 0x22→0x93, 0x33→0xC3, 0x44→0x1B.
- R6: With `en_rot`, the row index r is `op_b[1:0]`. `op_a` is taken as four bytes, where byte c is bits [8c+7:8c]. Output byte c equals input byte (c+r) mod 4, so r = 0 leaves the row unchanged. `op_b[31:2]` is ignored.
- R7: With no enable, `res` = `op_a` XOR `op_b`; for example, 0x53 XOR 0xCA = 0x99.
- R8: In GF-multiply mode, `op_a[31:8]` and `op_b[31:8]` have no effect on `res`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issued this cycle |
| op_a | input | 32 | First operand / state row / byte lanes |
| op_b | input | 32 | Second operand / row index in bits [1:0] |
| en_gfm | input | 1 | Select GF(2^8) multiply |
| en_sub | input | 1 | Select byte substitution |
| en_rot | input | 1 | Select row rotation |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result valid, one cycle after issue |

## Verification
The unit holds no state beyond its result register. A wrong internal decision therefore shows up at `res` on the cycle right after the faulty operation is issued. Examples of such faults are a mis-resolved priority, a bad reduction step, or an off-by-one rotation. A corrupted hold path shows up as `res` changing during an idle cycle.

A fault in the inversion chain usually touches only some byte values. For that reason the substitution is checked with several distinct byte patterns across all four lanes. The upper operand bits are driven with unrelated data in multiply and rotate modes, which exposes any leakage from them.

// File: rtl/aesx_pkg.sv
package aesx_pkg;

  localparam int BYTE_W = 8;

  function automatic logic [BYTE_W-1:0] gf_mul8(
    input logic [BYTE_W-1:0] a,
    input logic [BYTE_W-1:0] b,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = sh[BYTE_W-1] ? ((sh << 1) ^ poly) : (sh << 1);
    end
    return acc;
  endfunction

  // a^254 = a^-1 for nonzero a; 0 maps to 0 naturally
  function automatic logic [BYTE_W-1:0] gf_inv8(
    input logic [BYTE_W-1:0] a,
    input logic [BYTE_W-1:0] poly
  );
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] base;
    logic [BYTE_W-1:0] ex;
    acc  = 8'h01;
    base = a;
    ex   = 8'hFE;
    for (int i = 0; i < BYTE_W; i++) begin
      if (ex[i]) acc = gf_mul8(acc, base, poly);
      base = gf_mul8(base, base, poly);
    end
    return acc;
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] x, input int n);
    return (x << n) | (x >> (BYTE_W - n));
  endfunction

  function automatic logic [BYTE_W-1:0] affine8(
    input logic [BYTE_W-1:0] x,
    input logic [BYTE_W-1:0] c
  );
    return x ^ rotl8(x, 1) ^ rotl8(x, 2) ^ rotl8(x, 3) ^ rotl8(x, 4) ^ c;
  endfunction

endpackage

// File: rtl/aesx_gfmul.sv
module aesx_gfmul #(
  parameter int          DATA_W = 32,
  parameter logic [7:0]  POLY   = 8'h1B
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import aesx_pkg::*;

  always_comb begin
    y = '0;
    y[BYTE_W-1:0] = gf_mul8(a[BYTE_W-1:0], b[BYTE_W-1:0], POLY);
  end
endmodule

// File: rtl/aesx_sbox_lane.sv
module aesx_sbox_lane #(
  parameter logic [7:0] POLY = 8'h1B,
  parameter logic [7:0] AFF  = 8'h63
) (
  input  logic [7:0] x,
  output logic [7:0] y
);
  import aesx_pkg::*;

  logic [7:0] inv;

  always_comb begin
    inv = gf_inv8(x, POLY);
    y   = affine8(inv, AFF);
  end
endmodule

// File: rtl/aesx_rowrot.sv
module aesx_rowrot #(
  parameter int LANES = 4,
  parameter int LW    = $clog2(LANES)
) (
  input  logic [8*LANES-1:0] row,
  input  logic [LW-1:0]      amt,
  output logic [8*LANES-1:0] y
);
  for (genvar c = 0; c < LANES; c++) begin : g_col
    logic [LW-1:0] src;
    assign src = LW'(c) + amt;
    assign y[8*c +: 8] = row[8*src +: 8];
  end
endmodule

// File: rtl/aesx_unit.sv
module aesx_unit #(
  parameter int         DATA_W = 32,
  parameter logic [7:0] POLY   = 8'h1B,
  parameter logic [7:0] AFF    = 8'h63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic              en_gfm,
  input  logic              en_sub,
  input  logic              en_rot,
  output logic [DATA_W-1:0] res,
  output logic              res_valid
);
  localparam int LANES = DATA_W / 8;
  localparam int LW    = $clog2(LANES);

  logic [DATA_W-1:0] gf_y, sub_y, rot_y, nxt;

  aesx_gfmul #(.DATA_W(DATA_W), .POLY(POLY)) u_gf (
    .a(op_a), .b(op_b), .y(gf_y)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    aesx_sbox_lane #(.POLY(POLY), .AFF(AFF)) u_sb (
      .x(op_a[8*l +: 8]), .y(sub_y[8*l +: 8])
    );
  end

  aesx_rowrot #(.LANES(LANES), .LW(LW)) u_rot (
    .row(op_a), .amt(op_b[LW-1:0]), .y(rot_y)
  );

  always_comb begin
    if (en_gfm)      nxt = gf_y;
    else if (en_sub) nxt = sub_y;
    else if (en_rot) nxt = rot_y;
    else             nxt = op_a ^ op_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (res == '0 && !res_valid));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |-> $stable(res));

  assert_gf_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(en_gfm)) |-> (res[DATA_W-1:8] == '0));

  assert_sbox_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(!en_gfm && en_sub && op_a == '0))
      |-> (res == {LANES{AFF}}));

  assert_rot_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(!en_gfm && !en_sub && en_rot && op_b[LW-1:0] == '0))
      |-> (res == $past(op_a)));

  assert_xor_fallback_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(!en_gfm && !en_sub && !en_rot))
      |-> (res == $past(op_a ^ op_b)));
endmodule

// File: tb/aesx_unit_bench.sv
`timescale 1ns/1ps
module aesx_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        en_gfm = 1'b0, en_sub = 1'b0, en_rot = 1'b0;
  logic [31:0] res;
  logic        res_valid;

  int checks = 0;
  int bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_res = '0;
  bit          armed = 1'b0;

  always #2.5 clk = ~clk;

  aesx_unit u_aesx_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .en_gfm(en_gfm), .en_sub(en_sub), .en_rot(en_rot),
    .res(res), .res_valid(res_valid)
  );

  function automatic logic [31:0] rot_ref(input logic [31:0] a, input int r);
    logic [31:0] o;
    for (int c = 0; c < 4; c++) o[8*c +: 8] = a[8*((c + r) % 4) +: 8];
    return o;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input string tag, input logic g, input logic s, input logic r,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] exp);
    @(negedge clk);
    in_valid = 1'b1; en_gfm = g; en_sub = s; en_rot = r; op_a = a; op_b = b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; en_gfm = 1'b1; en_sub = 1'b1; en_rot = 1'b1;
      op_a = 32'hDEAD_BEEF; op_b = 32'h1234_5678;
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (armed) begin
      if (res_valid) begin
        if (exp_q.size() == 0) begin
          checks++; bad++;
          $display("FAIL R2 unexpected valid actual=%h expected=none", res);
        end else begin
          check(tag_q.pop_front(), res, exp_q.pop_front());
        end
      end else begin
        check("R2 hold", res, last_res);
      end
      last_res = res;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 res", res, 32'h0);
    check("R1 valid", {31'b0, res_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    armed = 1'b1;

    issue("R4 57*83", 1, 0, 0, 32'h0000_0057, 32'h0000_0083, 32'h0000_00C1);
    issue("R4 57*13", 1, 0, 0, 32'h0000_0057, 32'h0000_0013, 32'h0000_00FE);
    issue("R4 02*87", 1, 0, 0, 32'h0000_0002, 32'h0000_0087, 32'h0000_0015);
    issue("R4 00*x", 1, 0, 0, 32'h0000_0000, 32'h0000_00A7, 32'h0);
    issue("R8 upper ignored", 1, 0, 0, 32'hABCD_EF57, 32'h1234_5683, 32'h0000_00C1);
    issue("R5 sbox mix", 0, 1, 0, 32'h5300_01FF, 32'h0, 32'hED63_7C16);
    issue("R5 sbox seq", 0, 1, 0, 32'h1122_3344, 32'hFFFF_FFFF, 32'h8293_C31B);
    issue("R5 sbox zero", 0, 1, 0, 32'h0, 32'h0, 32'h6363_6363);
    for (int r = 0; r < 4; r++)
      issue($sformatf("R6 rot r=%0d", r), 0, 0, 1, 32'h4433_2211,
            32'hCAFE_0000 | r, rot_ref(32'h4433_2211, r));
    issue("R6 rot r=1 alt", 0, 0, 1, 32'hA1B2_C3D4, 32'hFFFF_FFFD, 32'hD4A1_B2C3);
    issue("R7 xor 53^CA", 0, 0, 0, 32'h0000_0053, 32'h0000_00CA, 32'h0000_0099);
    issue("R7 round key", 0, 0, 0, 32'h3243_F6A8, 32'h2B7E_1516, 32'h3243_F6A8 ^ 32'h2B7E_1516);
    issue("R3 all enables", 1, 1, 1, 32'h0000_0057, 32'h0000_0083, 32'h0000_00C1);
    issue("R3 sub over rot", 0, 1, 1, 32'h5300_01FF, 32'h0000_0001, 32'hED63_7C16);
    issue("R3 gf over sub", 1, 1, 0, 32'h0000_0053, 32'h0000_0001, 32'h0000_0053);
    idle(3);
    issue("R2 after idle", 0, 0, 1, 32'h4433_2211, 32'h2, 32'h2211_4433);
    idle(3);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; bad++;
      $display("FAIL R2 missing results actual=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #50000;
    checks++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule